// File: doc/BRIEF.md
# Interrupt Message Queue Controller

This block sits next to a small 16-bit processor core and owns the interrupt message path. Messages arrive from two places: a software interrupt instruction issued by the core, and external devices, which can post a message in any cycle. Each message is stored in a circular queue of 16-bit words. At every instruction boundary the block decides whether to take a message out of the queue and deliver it.

A message is delivered only when deferral is off. A delivery pushes the core's PC and then its A register onto the stack through a one-word-per-cycle memory port. It then redirects PC to the handler address and loads the message into A. If the handler address is zero, the message is thrown away. The block also runs the return sequence, which pops A and then PC. It executes the queue-control instruction, which switches deferral on or off. While an instruction sequence is running, the block holds a busy signal for that instruction's fixed cost in cycles.

Top module: `intq_ctrl`

## Requirements
- R1: After synchronous reset, deferral is off, the queue is empty (q_empty=1, q_full=0), q_overflow=0, busy=0 and mem_we=0.
- R2: Messages leave the queue in the order they entered. The queue holds at most DEPTH-1 messages. q_full is 1 exactly when it holds DEPTH-1, and q_empty is 1 exactly when it holds none.
- R3: A message offered while the queue is full is dropped, and q_overflow becomes 1 and stays 1 until reset. When a software message and a device message arrive in the same cycle, the software message is stored first.
- R4: A message is dequeued only in an idle cycle with boundary=1, deferral off and the queue non-empty. Otherwise the queue is unchanged.
- R5: When a message is dequeued with handler address vec non-zero, deferral turns on in the same edge. In the next cycle, the block writes PC to address SP-1. In the cycle after that, it writes A to SP-2 and raises done, pc_load (pc_next=vec), a_load (a_next=message) and sp_load (sp_next=SP-2).
- R6: When a message is dequeued with vec=0, the message is discarded. There is no memory write and no register load, and deferral is unchanged.
- R7: cmd_kind=2 (return) turns deferral off. In the next cycle it reads A from address SP. In the following cycle it reads PC from SP+1 with sp_next=SP+2. busy stays high for 3 cycles, with done in the last one.
- R8: cmd_kind=3 (queue control) turns deferral on if cmd_arg is non-zero and off if it is zero. busy stays high for 2 cycles, with done in the last one.
- R9: cmd_kind=1 (software interrupt) keeps busy high for 4 cycles, with done in the last one. It enqueues cmd_arg only if vec is non-zero at issue.
- R10: While busy, commands and boundary are ignored. In an idle cycle, a command (cmd_kind not 0) takes precedence over a boundary delivery.
- R11: A device message (dev_valid=1) is enqueued in any cycle, whatever the value of vec and whether or not the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_kind | input | 2 | 0 none, 1 software interrupt, 2 return, 3 queue control |
| cmd_arg | input | 16 | Operand of the command |
| boundary | input | 1 | Core is at an instruction boundary |
| vec | input | 16 | Handler address register value |
| core_pc | input | 16 | Current PC of the core |
| core_sp | input | 16 | Current SP of the core |
| core_a | input | 16 | Current A register of the core |
| dev_valid | input | 1 | Device posts a message |
| dev_msg | input | 16 | Device message |
| mem_we | output | 1 | Stack write enable |
| mem_addr | output | 16 | Stack address |
| mem_wdata | output | 16 | Stack write data |
| mem_rdata | input | 16 | Stack read data, same cycle as address |
| pc_load | output | 1 | Load pc_next into PC |
| pc_next | output | 16 | New PC value |
| a_load | output | 1 | Load a_next into A |
| a_next | output | 16 | New A value |
| sp_load | output | 1 | Load sp_next into SP |
| sp_next | output | 16 | New SP value |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Last cycle of a sequence |
| deferred | output | 1 | Deferral flag |
| q_full | output | 1 | Queue holds DEPTH-1 messages |
| q_empty | output | 1 | Queue holds no message |
| q_overflow | output | 1 | Sticky: a message was dropped because the queue was full |

## Verification
The hardest situation to reach is a cycle in which a software message and a device message both arrive while exactly one slot is free. Only then do the ordering rule and the overflow rule act together. The bench builds the block with a queue depth of 8 and fills it to one slot below full with device messages. It then issues a software interrupt and a device message on the same edge, and drains the queue to confirm that the software message survived and came out last. A second hard case is a boundary that arrives while a sequence is running. The bench holds boundary high for the whole duration of a software interrupt and checks that nothing is delivered.

// File: rtl/intq_pkg.sv
package intq_pkg;

    localparam int WORD_W = 16;
    localparam int WAIT_W = 2;

    localparam int COST_SWINT  = 4;
    localparam int COST_RETURN = 3;
    localparam int COST_QCTL   = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_SWINT  = 2'd1,
        CMD_RETURN = 2'd2,
        CMD_QCTL   = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_A,
        ST_POP_A,
        ST_POP_PC,
        ST_WAIT
    } state_e;

    typedef struct packed {
        word_t pc;
        word_t sp;
        word_t a;
        word_t vec;
        word_t msg;
    } ctx_t;

endpackage

// File: rtl/intq_ring.sv
module intq_ring
    import intq_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            enq_en,
    input  logic [1:0][WORD_W-1:0] enq_data,
    input  logic                  deq,
    output word_t                 front,
    output logic                  full,
    output logic                  empty,
    output logic                  overflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int NPORT = 2;
    localparam int CNT_W = $clog2(NPORT + 1);

    word_t            slots [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic             ovf_q;
    logic [PTR_W:0]   used, room;
    logic [NPORT-1:0] take;
    logic [PTR_W-1:0] wr_ptr [NPORT];
    logic [CNT_W-1:0] n_take;

    always_comb begin
        used   = {1'b0, PTR_W'(tail_q - head_q)};
        room   = (PTR_W+1)'(DEPTH - 1) - used;
        n_take = '0;
        for (int p = 0; p < NPORT; p++) begin
            wr_ptr[p] = tail_q + PTR_W'(n_take);
            take[p]   = enq_en[p] && ((PTR_W+1)'(n_take) < room);
            if (take[p]) n_take = n_take + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            ovf_q  <= 1'b0;
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++)
                if (take[p]) slots[wr_ptr[p]] <= enq_data[p];
            tail_q <= tail_q + PTR_W'(n_take);
            if (deq) head_q <= head_q + PTR_W'(1);
            if (|(enq_en & ~take)) ovf_q <= 1'b1;
        end
    end

    assign front    = slots[head_q];
    assign empty    = (head_q == tail_q);
    assign full     = (used == (PTR_W+1)'(DEPTH - 1));
    assign overflow = ovf_q;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        deq |-> !empty);  // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);  // R3
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));  // R2

endmodule

// File: rtl/intq_seq.sv
module intq_seq
    import intq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cmd_kind,
    input  word_t      cmd_arg,
    input  logic       boundary,
    input  word_t      vec,
    input  word_t      cur_pc,
    input  word_t      cur_sp,
    input  word_t      cur_a,
    input  logic       q_empty,
    input  word_t      q_front,
    output logic       deq,
    output logic       sw_enq,
    output logic       mem_we,
    output word_t      mem_addr,
    output word_t      mem_wdata,
    input  word_t      mem_rdata,
    output logic       pc_load,
    output word_t      pc_next,
    output logic       a_load,
    output word_t      a_next,
    output logic       sp_load,
    output word_t      sp_next,
    output logic       busy,
    output logic       done,
    output logic       deferred
);
    state_e            st_q;
    ctx_t              ctx_q;
    logic [WAIT_W-1:0] wait_q;
    logic              defer_q;
    cmd_e              cmd;
    logic              idle, take_cmd;

    assign cmd      = cmd_e'(cmd_kind);
    assign idle     = (st_q == ST_IDLE);
    assign take_cmd = idle && (cmd != CMD_NONE);
    assign deq      = idle && !take_cmd && boundary && !defer_q && !q_empty;
    assign sw_enq   = take_cmd && (cmd == CMD_SWINT) && (vec != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            ctx_q   <= '0;
            wait_q  <= '0;
            defer_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (take_cmd) begin
                        unique case (cmd)
                            CMD_SWINT: begin
                                st_q   <= ST_WAIT;
                                wait_q <= WAIT_W'(COST_SWINT - 1);
                            end
                            CMD_RETURN: begin
                                defer_q  <= 1'b0;
                                ctx_q.sp <= cur_sp;
                                st_q     <= ST_POP_A;
                            end
                            CMD_QCTL: begin
                                defer_q <= (cmd_arg != '0);
                                st_q    <= ST_WAIT;
                                wait_q  <= WAIT_W'(COST_QCTL - 1);
                            end
                            default: ;
                        endcase
                    end else if (deq && vec != '0) begin
                        defer_q <= 1'b1;
                        ctx_q   <= '{pc: cur_pc, sp: cur_sp, a: cur_a,
                                     vec: vec, msg: q_front};
                        st_q    <= ST_PUSH_PC;
                    end
                end
                ST_PUSH_PC: st_q <= ST_PUSH_A;
                ST_PUSH_A:  st_q <= ST_IDLE;
                ST_POP_A:   st_q <= ST_POP_PC;
                ST_POP_PC: begin
                    st_q   <= ST_WAIT;
                    wait_q <= WAIT_W'(COST_RETURN - 3);
                end
                ST_WAIT: begin
                    if (wait_q == '0) st_q <= ST_IDLE;
                    else              wait_q <= wait_q - WAIT_W'(1);
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pc_load   = 1'b0;
        pc_next   = '0;
        a_load    = 1'b0;
        a_next    = '0;
        sp_load   = 1'b0;
        sp_next   = '0;
        unique case (st_q)
            ST_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_addr  = ctx_q.sp - 16'd1;
                mem_wdata = ctx_q.pc;
            end
            ST_PUSH_A: begin
                mem_we    = 1'b1;
                mem_addr  = ctx_q.sp - 16'd2;
                mem_wdata = ctx_q.a;
                pc_load   = 1'b1;
                pc_next   = ctx_q.vec;
                a_load    = 1'b1;
                a_next    = ctx_q.msg;
                sp_load   = 1'b1;
                sp_next   = ctx_q.sp - 16'd2;
            end
            ST_POP_A: begin
                mem_addr = ctx_q.sp;
                a_load   = 1'b1;
                a_next   = mem_rdata;
            end
            ST_POP_PC: begin
                mem_addr = ctx_q.sp + 16'd1;
                pc_load  = 1'b1;
                pc_next  = mem_rdata;
                sp_load  = 1'b1;
                sp_next  = ctx_q.sp + 16'd2;
            end
            default: ;
        endcase
    end

    assign busy     = !idle;
    assign done     = (st_q == ST_PUSH_A) || (st_q == ST_WAIT && wait_q == '0);
    assign deferred = defer_q;

    AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PUSH_PC) |=> (mem_we && mem_addr == $past(mem_addr) - 16'd1));  // R5
    AST_DEFER_WHILE_PUSH: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> deferred);  // R5
    AST_RETURN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_POP_A) |-> !deferred);  // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R10
    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);  // R9

endmodule

// File: rtl/intq_ctrl.sv
module intq_ctrl
    import intq_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cmd_kind,
    input  logic [15:0] cmd_arg,
    input  logic        boundary,
    input  logic [15:0] vec,
    input  logic [15:0] core_pc,
    input  logic [15:0] core_sp,
    input  logic [15:0] core_a,
    input  logic        dev_valid,
    input  logic [15:0] dev_msg,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic        pc_load,
    output logic [15:0] pc_next,
    output logic        a_load,
    output logic [15:0] a_next,
    output logic        sp_load,
    output logic [15:0] sp_next,
    output logic        busy,
    output logic        done,
    output logic        deferred,
    output logic        q_full,
    output logic        q_empty,
    output logic        q_overflow
);
    logic  deq, sw_enq;
    word_t front;

    intq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .enq_en   ({dev_valid, sw_enq}),
        .enq_data ({dev_msg, cmd_arg}),
        .deq      (deq),
        .front    (front),
        .full     (q_full),
        .empty    (q_empty),
        .overflow (q_overflow)
    );

    intq_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_kind  (cmd_kind),
        .cmd_arg   (cmd_arg),
        .boundary  (boundary),
        .vec       (vec),
        .cur_pc    (core_pc),
        .cur_sp    (core_sp),
        .cur_a     (core_a),
        .q_empty   (q_empty),
        .q_front   (front),
        .deq       (deq),
        .sw_enq    (sw_enq),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .pc_load   (pc_load),
        .pc_next   (pc_next),
        .a_load    (a_load),
        .a_next    (a_next),
        .sp_load   (sp_load),
        .sp_next   (sp_next),
        .busy      (busy),
        .done      (done),
        .deferred  (deferred)
    );

endmodule

// File: tb/test_intq_ctrl.sv
module test_intq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd_kind = 2'd0;
    logic [15:0] cmd_arg = '0;
    logic        boundary = 1'b0;
    logic [15:0] vec = '0;
    logic [15:0] core_pc = '0, core_sp = '0, core_a = '0;
    logic        dev_valid = 1'b0;
    logic [15:0] dev_msg = '0;
    logic        mem_we, pc_load, a_load, sp_load, busy, done, deferred;
    logic        q_full, q_empty, q_overflow;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_next, a_next, sp_next;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    logic [31:0] exp_wr [$];

    always #2.5 clk = ~clk;

    assign mem_rdata = (mem_addr == 16'h7FFE) ? 16'hAAAA :
                       (mem_addr == 16'h7FFF) ? 16'hBBBB : 16'h0000;

    intq_ctrl #(.DEPTH(8)) i_intq_ctrl (
        .clk(clk), .rst(rst), .cmd_kind(cmd_kind), .cmd_arg(cmd_arg),
        .boundary(boundary), .vec(vec), .core_pc(core_pc), .core_sp(core_sp),
        .core_a(core_a), .dev_valid(dev_valid), .dev_msg(dev_msg),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .pc_load(pc_load), .pc_next(pc_next),
        .a_load(a_load), .a_next(a_next), .sp_load(sp_load), .sp_next(sp_next),
        .busy(busy), .done(done), .deferred(deferred), .q_full(q_full),
        .q_empty(q_empty), .q_overflow(q_overflow)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: every stack write must match the next scoreboard item
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (exp_wr.size() == 0) begin
                check("R6 unexpected write addr", mem_addr, 16'hFFFF);
            end else begin
                logic [31:0] e;
                e = exp_wr.pop_front();
                check("R5 write addr", mem_addr, e[31:16]);
                check("R5 write data", mem_wdata, e[15:0]);
            end
        end
    end

    task automatic dev_push(logic [15:0] m);
        dev_valid = 1'b1; dev_msg = m;
        @(negedge clk);
        dev_valid = 1'b0;
    endtask

    task automatic deliver(logic [15:0] m);
        core_pc = m + 16'h0100; core_sp = 16'h8000; core_a = 16'h5555;
        vec = 16'h4000; boundary = 1'b1;
        exp_wr.push_back({16'h7FFF, m + 16'h0100});
        exp_wr.push_back({16'h7FFE, 16'h5555});
        @(negedge clk);
        boundary = 1'b0;
        check("R5 deferred set", 16'(deferred), 16'd1);
        check("R5 busy push", 16'(busy), 16'd1);
        @(negedge clk);
        check("R5 pc_load", 16'(pc_load), 16'd1);
        check("R5 pc_next", pc_next, 16'h4000);
        check("R2 a_next message order", a_next, m);
        check("R5 sp_next", sp_next, 16'h7FFE);
        check("R5 done", 16'(done), 16'd1);
        @(negedge clk);
        check("R5 idle after", 16'(busy), 16'd0);
    endtask

    task automatic qctl(logic [15:0] op);
        cmd_kind = 2'd3; cmd_arg = op;
        @(negedge clk);
        cmd_kind = 2'd0;
        check("R8 deferred", 16'(deferred), 16'(op != 0));
        check("R8 busy c1", 16'(busy), 16'd1);
        check("R8 no done c1", 16'(done), 16'd0);
        @(negedge clk);
        check("R8 done c2", 16'(done), 16'd1);
        @(negedge clk);
        check("R8 idle", 16'(busy), 16'd0);
    endtask

    task automatic swint(logic [15:0] op, logic [15:0] v, bit hold_bnd);
        cmd_kind = 2'd1; cmd_arg = op; vec = v;
        if (hold_bnd) boundary = 1'b1;
        @(negedge clk);
        cmd_kind = 2'd0;
        check("R9 busy c1", 16'(busy), 16'd1);
        repeat (2) begin
            @(negedge clk);
            check("R9 no early done", 16'(done), 16'd0);
        end
        @(negedge clk);
        boundary = 1'b0;
        check("R9 done c4", 16'(done), 16'd1);
        @(negedge clk);
        check("R9 idle", 16'(busy), 16'd0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 deferred", 16'(deferred), 16'd0);
        check("R1 q_empty", 16'(q_empty), 16'd1);
        check("R1 q_full", 16'(q_full), 16'd0);
        check("R1 q_overflow", 16'(q_overflow), 16'd0);
        check("R1 busy", 16'(busy), 16'd0);
        check("R1 mem_we", 16'(mem_we), 16'd0);
    endtask

    initial begin
        do_reset();

        // R6: zero handler address discards
        dev_push(16'h0101);
        check("R11 dev enqueued", 16'(q_empty), 16'd0);
        vec = 16'h0000; boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        check("R6 discarded", 16'(q_empty), 16'd1);
        check("R6 no busy", 16'(busy), 16'd0);
        check("R6 deferred unchanged", 16'(deferred), 16'd0);
        check("R6 no pc_load", 16'(pc_load), 16'd0);

        // R2 order, R4 deferral blocking
        dev_push(16'h00A1); dev_push(16'h00A2); dev_push(16'h00A3);
        deliver(16'h00A1);
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        check("R4 blocked busy", 16'(busy), 16'd0);
        check("R4 queue kept", 16'(q_empty), 16'd0);
        qctl(16'h0000);
        deliver(16'h00A2);
        qctl(16'h0000);
        deliver(16'h00A3);
        check("R2 drained", 16'(q_empty), 16'd1);

        // R7 return
        core_sp = 16'h7FFE;
        cmd_kind = 2'd2;
        @(negedge clk);
        cmd_kind = 2'd0;
        check("R7 deferred cleared", 16'(deferred), 16'd0);
        check("R7 a_load", 16'(a_load), 16'd1);
        check("R7 a_next", a_next, 16'hAAAA);
        @(negedge clk);
        check("R7 pc_next", pc_next, 16'hBBBB);
        check("R7 sp_next", sp_next, 16'h8000);
        check("R7 no early done", 16'(done), 16'd0);
        @(negedge clk);
        check("R7 done c3", 16'(done), 16'd1);
        @(negedge clk);
        check("R7 idle", 16'(busy), 16'd0);

        // R8
        qctl(16'h0005);
        qctl(16'h0000);

        // R9
        swint(16'h0077, 16'h0000, 1'b0);
        check("R9 ignored with vec zero", 16'(q_empty), 16'd1);
        // R10: boundary held through the busy window
        swint(16'h0088, 16'h4000, 1'b1);
        check("R10 no delivery while busy", 16'(q_empty), 16'd0);
        deliver(16'h0088);
        qctl(16'h0000);

        // R11: device message during a busy sequence
        cmd_kind = 2'd3; cmd_arg = 16'h0000;
        dev_valid = 1'b1; dev_msg = 16'h0999;
        @(negedge clk);
        cmd_kind = 2'd0; dev_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11 dev while busy", 16'(q_empty), 16'd0);
        deliver(16'h0999);
        qctl(16'h0000);

        // R3 overflow and same-cycle ordering, depth 8 holds 7
        dev_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            dev_msg = 16'h0010 + 16'(i);
            @(negedge clk);
        end
        dev_valid = 1'b0;
        check("R2 not full at 6", 16'(q_full), 16'd0);
        cmd_kind = 2'd1; cmd_arg = 16'h0ABC; vec = 16'h4000;
        dev_valid = 1'b1; dev_msg = 16'h0DEF;
        @(negedge clk);
        cmd_kind = 2'd0; dev_valid = 1'b0;
        check("R2 full at 7", 16'(q_full), 16'd1);
        check("R3 overflow set", 16'(q_overflow), 16'd1);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            deliver(16'h0010 + 16'(i));
            qctl(16'h0000);
        end
        deliver(16'h0ABC);
        qctl(16'h0000);
        check("R3 dev dropped", 16'(q_empty), 16'd1);
        check("R3 overflow sticky", 16'(q_overflow), 16'd1);

        do_reset();
        check("R1 scoreboard drained", 16'(exp_wr.size()), 16'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule